// File: doc/BRIEF.md
# Ordered Memory Access Checking Unit

This unit sits between a load/store requester and a simple byte-addressed memory port. A request carries an address, a size given as log2 of the byte count, a store/load select, a fetch/data select for loads, and three ordering flags: acquire, release and reserve. The reserve flag marks a reserved load or a conditional store. The unit screens each request before anything reaches memory. It tests natural alignment only for the flag mixes that demand it, and it refuses the flag mixes it does not support. It tags every accepted request with an ordering class and a reserve marker for the memory side.

An accepted load becomes one read command. An accepted store becomes two commands: an address announce, then a value write, and both carry the same class. A failed read or write comes back as a standard exception cause code. An unsupported flag mix is reported on its own flag. A request that is refused in screening never drives the memory port. Every accepted request gets exactly one response pulse.

Top module: `ordered_access_unit`

## Requirements
- R1: After reset, reqReady is 1 and rspValid and memCmd are 0.
- R2: A load is tested for alignment only when acquire or reserve is set. The test fails when the address modulo (1 << reqSize) is non-zero. A failure responds with rspFault=1 and rspCause=4, and no memory command is issued.
- R3: A store is tested for alignment only when release or reserve is set. A failure responds with rspFault=1 and rspCause=6, and no memory command is issued.
- R4: A load with release set and acquire clear, with reserve either way, responds with rspUnsupported=1, rspFault=0 and rspCause=0, and issues no memory command.
- R5: A store with acquire set and release clear, with reserve either way, responds with rspUnsupported=1, rspFault=0 and rspCause=0, and issues no memory command.
- R6: When a request both fails alignment and uses an unsupported flag mix, the misalignment fault is reported and rspUnsupported stays 0.
- R7: memClass encodes the ordering: 0 plain, 1 acquire only, 2 release only, 3 acquire and release on a load, 4 acquire and release on a store. memExcl equals the reserve flag.
- R8: An accepted load issues exactly one command with memKind=0 (read), carrying the request address and size. On success rspData is memRdata with every bit at or above 8<<reqSize forced to 0.
- R9: A failed read (memOk=0) responds with rspFault=1 and with rspCause=1 for a fetch or rspCause=5 for a data load. rspData is then 0.
- R10: An accepted store issues memKind=1 (announce) and then memKind=2 (write) to the same address. The write data is reqWdata with bits at or above 8<<reqSize cleared. A failed write responds with rspCause=7. A successful store responds with no fault.
- R11: reqReady is 1 only while no request is in flight. A command is held, with the same kind, until memAck. Each accepted request yields exactly one single-cycle rspValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit can accept a request |
| reqStore | input | 1 | 1 store, 0 load |
| reqFetch | input | 1 | Load is an instruction fetch |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | log2 of access bytes |
| reqAcquire | input | 1 | Acquire ordering flag |
| reqRelease | input | 1 | Release ordering flag |
| reqReserve | input | 1 | Reserved load / conditional store |
| reqWdata | input | DATA_W | Store value |
| memCmd | output | 1 | Memory command valid |
| memKind | output | 2 | 0 read, 1 announce, 2 write |
| memAddr | output | ADDR_W | Command address |
| memSize | output | 2 | Command size |
| memClass | output | 3 | Ordering class |
| memExcl | output | 1 | Reserve marker |
| memWdata | output | DATA_W | Masked write value |
| memAck | input | 1 | Command accepted/completed |
| memOk | input | 1 | Access succeeded (valid with memAck) |
| memRdata | input | DATA_W | Read value (valid with memAck) |
| rspValid | output | 1 | Response pulse |
| rspData | output | DATA_W | Load result |
| rspFault | output | 1 | Exception raised |
| rspCause | output | 4 | Exception cause code |
| rspUnsupported | output | 1 | Flag mix not supported |

## Verification
The alignment test and the unsupported-mix test run on the same request in the same cycle. Which one wins decides the response. The bench provokes this by sweeping every size, every flag combination and all eight low address offsets. This covers misaligned release-only reserved loads and misaligned acquire-only conditional stores, where both conditions hold at once. The bench judges each response against its own arithmetic model: the misalignment cause must appear with the unsupported flag low, and memory must stay idle. A second overlap is memAck arriving in the first cycle of a command, including the announce-to-write hand-off. The bench triggers it with zero-latency acknowledges and checks the kind sequence it logs.

// File: rtl/oau_pkg.sv
package oau_pkg;

  typedef enum logic [2:0] {
    CLS_PLAIN      = 3'd0,
    CLS_ACQ        = 3'd1,
    CLS_REL        = 3'd2,
    CLS_STRONG_ACQ = 3'd3,
    CLS_STRONG_REL = 3'd4
  } ordClass_e;

  typedef enum logic [1:0] {
    KIND_READ     = 2'd0,
    KIND_ANNOUNCE = 2'd1,
    KIND_WRITE    = 2'd2
  } memKind_e;

  localparam logic [3:0] CAUSE_NONE         = 4'd0;
  localparam logic [3:0] CAUSE_FETCH_ACCESS = 4'd1;
  localparam logic [3:0] CAUSE_LOAD_ALIGN   = 4'd4;
  localparam logic [3:0] CAUSE_LOAD_ACCESS  = 4'd5;
  localparam logic [3:0] CAUSE_STORE_ALIGN  = 4'd6;
  localparam logic [3:0] CAUSE_STORE_ACCESS = 4'd7;

  // control -> datapath strobes
  typedef struct packed {
    logic captureReq;  // latch request and screening verdict
    logic captureRsp;  // latch memory outcome (read or write ack)
  } dpStrobes_t;

endpackage

// File: rtl/oau_screen.sv
// Combinational screening of a request: alignment, flag legality, class.
module oau_screen
  import oau_pkg::*;
#(
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 2
) (
  input  logic              isStore,
  input  logic [SIZE_W-1:0] size,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic              acquire,
  input  logic              release_,
  input  logic              reserve,
  output logic              misaligned,
  output logic              unsupported,
  output ordClass_e         ordClass
);

  logic [OFF_W-1:0] lowMask;
  logic             offsetBad;
  logic             needAlign;
  logic             badMix;

  always_comb begin
    lowMask   = OFF_W'((32'd1 << size) - 32'd1);
    offsetBad = |(addrLow & lowMask);
    needAlign = isStore ? (release_ | reserve) : (acquire | reserve);
    badMix    = isStore ? (acquire & ~release_) : (release_ & ~acquire);
    // alignment fault outranks an unsupported mix
    misaligned  = needAlign & offsetBad;
    unsupported = badMix & ~misaligned;
  end

  always_comb begin
    if (acquire && release_)  ordClass = isStore ? CLS_STRONG_REL : CLS_STRONG_ACQ;
    else if (acquire)         ordClass = CLS_ACQ;
    else if (release_)        ordClass = CLS_REL;
    else                      ordClass = CLS_PLAIN;
  end

endmodule

// File: rtl/oau_datapath.sv
// Request/response registers, lane masking and cause selection.
module oau_datapath
  import oau_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              memCmd,
  input  logic              reqStore,
  input  logic              reqFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqAcquire,
  input  logic              reqRelease,
  input  logic              reqReserve,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              memOk,
  input  logic [DATA_W-1:0] memRdata,
  output logic              blocked,
  output logic              isStoreQ,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SIZE_W-1:0] memSize,
  output logic [2:0]        memClass,
  output logic              memExcl,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspFault,
  output logic [3:0]        rspCause,
  output logic              rspUnsupported
);

  localparam int BYTES = DATA_W / 8;

  logic              screenMis;
  logic              screenUnsup;
  ordClass_e         screenClass;

  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic              storeQ;
  logic              fetchQ;
  logic              exclQ;
  ordClass_e         classQ;
  logic [DATA_W-1:0] wdataQ;
  logic              misQ;
  logic              unsupQ;
  logic              failQ;
  logic [DATA_W-1:0] rdataQ;
  logic [DATA_W-1:0] laneMask;

  oau_screen #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) screen_i (
    .isStore    (reqStore),
    .size       (reqSize),
    .addrLow    (reqAddr[OFF_W-1:0]),
    .acquire    (reqAcquire),
    .release_   (reqRelease),
    .reserve    (reqReserve),
    .misaligned (screenMis),
    .unsupported(screenUnsup),
    .ordClass   (screenClass)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign laneMask[8*b +: 8] = {8{(32'(b) < (32'd1 << sizeQ))}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      storeQ <= 1'b0;
      fetchQ <= 1'b0;
      exclQ  <= 1'b0;
      classQ <= CLS_PLAIN;
      wdataQ <= '0;
      misQ   <= 1'b0;
      unsupQ <= 1'b0;
      failQ  <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (strobes.captureReq) begin
        addrQ  <= reqAddr;
        sizeQ  <= reqSize;
        storeQ <= reqStore;
        fetchQ <= reqFetch & ~reqStore;
        exclQ  <= reqReserve;
        classQ <= screenClass;
        wdataQ <= reqWdata;
        misQ   <= screenMis;
        unsupQ <= screenUnsup;
        failQ  <= 1'b0;
        rdataQ <= '0;
      end else if (strobes.captureRsp) begin
        failQ  <= ~memOk;
        rdataQ <= (memOk && !storeQ) ? (memRdata & laneMask) : '0;
      end
    end
  end

  always_comb begin
    blocked        = misQ | unsupQ;
    isStoreQ       = storeQ;
    memAddr        = addrQ;
    memSize        = sizeQ;
    memClass       = classQ;
    memExcl        = exclQ;
    memWdata       = wdataQ & laneMask;
    rspData        = (misQ || unsupQ || failQ) ? '0 : rdataQ;
    rspUnsupported = unsupQ;
    rspFault       = misQ | (failQ & ~unsupQ);
    if (misQ)       rspCause = storeQ ? CAUSE_STORE_ALIGN : CAUSE_LOAD_ALIGN;
    else if (failQ) rspCause = storeQ ? CAUSE_STORE_ACCESS
                               : (fetchQ ? CAUSE_FETCH_ACCESS : CAUSE_LOAD_ACCESS);
    else            rspCause = CAUSE_NONE;
  end

  // a screened-out request must never reach the memory port
  assert_blocked_no_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    memCmd |-> !misQ && !unsupQ);

  // an outcome is only latched for a request that passed screening
  assert_capture_screened_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureRsp |-> !blocked);

endmodule

// File: rtl/oau_control.sv
// Sequencer: accept, dispatch, read or announce+write, respond.
module oau_control
  import oau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memAck,
  input  logic       blocked,
  input  logic       isStoreQ,
  output logic       reqReady,
  output logic       memCmd,
  output logic [1:0] memKind,
  output logic       rspValid,
  output dpStrobes_t strobes
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DISPATCH, ST_READ, ST_ANNOUNCE, ST_WRITE, ST_RESP
  } state_e;

  state_e   state, stateNext;
  memKind_e kindNow;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (reqValid) stateNext = ST_DISPATCH;
      ST_DISPATCH: begin
        if (blocked)       stateNext = ST_RESP;
        else if (isStoreQ) stateNext = ST_ANNOUNCE;
        else               stateNext = ST_READ;
      end
      ST_READ:     if (memAck) stateNext = ST_RESP;
      ST_ANNOUNCE: if (memAck) stateNext = ST_WRITE;
      ST_WRITE:    if (memAck) stateNext = ST_RESP;
      ST_RESP:     stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    unique case (state)
      ST_ANNOUNCE: kindNow = KIND_ANNOUNCE;
      ST_WRITE:    kindNow = KIND_WRITE;
      default:     kindNow = KIND_READ;
    endcase
    reqReady           = (state == ST_IDLE);
    memCmd             = (state == ST_READ) || (state == ST_ANNOUNCE) || (state == ST_WRITE);
    memKind            = kindNow;
    rspValid           = (state == ST_RESP);
    strobes.captureReq = reqValid && (state == ST_IDLE);
    strobes.captureRsp = memAck && ((state == ST_READ) || (state == ST_WRITE));
  end

  assert_cmd_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    memCmd && !memAck |=> memCmd && $stable(memKind));

  assert_write_follows_announce_R10: assert property (@(posedge clk) disable iff (!rstN)
    memCmd && memAck && memKind == KIND_ANNOUNCE |=> memCmd && memKind == KIND_WRITE);

  assert_rsp_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

endmodule

// File: rtl/ordered_access_unit.sv
module ordered_access_unit
  import oau_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqStore,
  input  logic              reqFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqAcquire,
  input  logic              reqRelease,
  input  logic              reqReserve,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              memCmd,
  output logic [1:0]        memKind,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [2:0]        memClass,
  output logic              memExcl,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic              memOk,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspFault,
  output logic [3:0]        rspCause,
  output logic              rspUnsupported
);

  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int SIZE_W = 2;

  dpStrobes_t strobes;
  logic       blocked;
  logic       isStoreQ;

  oau_control control_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .memAck  (memAck),
    .blocked (blocked),
    .isStoreQ(isStoreQ),
    .reqReady(reqReady),
    .memCmd  (memCmd),
    .memKind (memKind),
    .rspValid(rspValid),
    .strobes (strobes)
  );

  oau_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) datapath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .memCmd        (memCmd),
    .reqStore      (reqStore),
    .reqFetch      (reqFetch),
    .reqAddr       (reqAddr),
    .reqSize       (reqSize),
    .reqAcquire    (reqAcquire),
    .reqRelease    (reqRelease),
    .reqReserve    (reqReserve),
    .reqWdata      (reqWdata),
    .memOk         (memOk),
    .memRdata      (memRdata),
    .blocked       (blocked),
    .isStoreQ      (isStoreQ),
    .memAddr       (memAddr),
    .memSize       (memSize),
    .memClass      (memClass),
    .memExcl       (memExcl),
    .memWdata      (memWdata),
    .rspData       (rspData),
    .rspFault      (rspFault),
    .rspCause      (rspCause),
    .rspUnsupported(rspUnsupported)
  );

endmodule

// File: tb/ordered_access_unit_tb_top.sv
`timescale 1ns/1ps
module ordered_access_unit_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqStore = 1'b0;
  logic              reqFetch = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = '0;
  logic              reqAcquire = 1'b0;
  logic              reqRelease = 1'b0;
  logic              reqReserve = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              memCmd;
  logic [1:0]        memKind;
  logic [ADDR_W-1:0] memAddr;
  logic [1:0]        memSize;
  logic [2:0]        memClass;
  logic              memExcl;
  logic [DATA_W-1:0] memWdata;
  logic              memAck = 1'b0;
  logic              memOk = 1'b0;
  logic [DATA_W-1:0] memRdata = '0;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              rspFault;
  logic [3:0]        rspCause;
  logic              rspUnsupported;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // memory model state and command log
  int                lat = 0;
  int                cnt = 0;
  int                cmdN = 0;
  logic [1:0]        kindLog [2];
  logic [ADDR_W-1:0] addrLog [2];
  logic [1:0]        sizeLog;
  logic [2:0]        classLog [2];
  logic              exclLog;
  logic [DATA_W-1:0] wdataLog;

  always #10 clk = ~clk;  // 50 MHz

  ordered_access_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

  function automatic logic [DATA_W-1:0] rpat(input logic [ADDR_W-1:0] a);
    return {a, ~a, a ^ 16'h5A5A, a + 16'h1111};
  endfunction

  function automatic logic [DATA_W-1:0] sizeMask(input int s);
    return (s == 3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
      cnt = 0;
    end else if (memCmd) begin
      if (cnt == lat) begin
        memAck   = 1'b1;
        memOk    = (memAddr[ADDR_W-1 -: 4] != 4'hF);
        memRdata = rpat(memAddr);
        if (cmdN < 2) begin
          kindLog[cmdN]  = memKind;
          addrLog[cmdN]  = memAddr;
          classLog[cmdN] = memClass;
        end
        sizeLog = memSize;
        exclLog = memExcl;
        if (memKind == 2'd2) wdataLog = memWdata;
        cmdN++;
        cnt = 0;
      end else begin
        cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic runTxn(input bit st, input bit fe, input int sz, input bit aq, input bit rl,
                        input bit rs, input logic [ADDR_W-1:0] a, input int l);
    bit mis, unsup, memFail, passes;
    logic [3:0] eCause;
    logic [2:0] eClass;
    logic [DATA_W-1:0] wd;
    mis     = (st ? (rl | rs) : (aq | rs)) && ((int'(a) % (1 << sz)) != 0);
    unsup   = !mis && (st ? (aq && !rl) : (rl && !aq));
    passes  = !mis && !unsup;
    memFail = (a[ADDR_W-1 -: 4] == 4'hF);
    eClass  = (aq && rl) ? (st ? 3'd4 : 3'd3) : aq ? 3'd1 : rl ? 3'd2 : 3'd0;
    if (mis)          eCause = st ? 4'd6 : 4'd4;
    else if (unsup)   eCause = 4'd0;
    else if (memFail) eCause = st ? 4'd7 : (fe ? 4'd1 : 4'd5);
    else              eCause = 4'd0;
    wd = {a ^ 16'hC3C3, a, ~a, 16'h0F0F} ^ {4{16'(sz)}};

    @(negedge clk);
    lat = l; cnt = 0; cmdN = 0;
    check(reqReady == 1'b1, "R11 ready when idle", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqStore = st; reqFetch = fe; reqSize = 2'(sz);
    reqAcquire = aq; reqRelease = rl; reqReserve = rs; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R11 busy after accept", 64'(reqReady), 64'd0);
    while (!rspValid) @(negedge clk);

    if (mis) begin
      check(rspFault && rspCause == eCause && !rspUnsupported, st ? "R3 misaligned store" : "R2 misaligned load",
            64'({rspFault, rspUnsupported, rspCause}), 64'({2'b10, eCause}));
      if ((st && aq && !rl) || (!st && rl && !aq))
        check(!rspUnsupported, "R6 misalign outranks unsupported", 64'(rspUnsupported), 64'd0);
      check(cmdN == 0, st ? "R3 no command" : "R2 no command", 64'(cmdN), 64'd0);
    end else if (unsup) begin
      check(rspUnsupported && !rspFault && rspCause == 4'd0, st ? "R5 unsupported store" : "R4 unsupported load",
            64'({rspFault, rspUnsupported, rspCause}), 64'({2'b01, 4'd0}));
      check(cmdN == 0, st ? "R5 no command" : "R4 no command", 64'(cmdN), 64'd0);
    end else begin
      check(classLog[0] == eClass, "R7 class", 64'(classLog[0]), 64'(eClass));
      check(exclLog == rs, "R7 reserve marker", 64'(exclLog), 64'(rs));
      check(sizeLog == 2'(sz), "R8 size passed", 64'(sizeLog), 64'(sz));
      if (!st) begin
        check(cmdN == 1 && kindLog[0] == 2'd0 && addrLog[0] == a, "R8 one read",
              64'({cmdN[7:0], kindLog[0], addrLog[0]}), 64'({8'd1, 2'd0, a}));
        if (memFail) begin
          check(rspFault && rspCause == eCause, "R9 read fault cause", 64'({rspFault, rspCause}), 64'({1'b1, eCause}));
          check(rspData == '0, "R9 no data on fault", rspData, 64'd0);
        end else begin
          check(!rspFault && rspData == (rpat(a) & sizeMask(sz)), "R8 read data", rspData, rpat(a) & sizeMask(sz));
        end
      end else begin
        check(cmdN == 2 && kindLog[0] == 2'd1 && kindLog[1] == 2'd2, "R10 announce then write",
              64'({cmdN[7:0], kindLog[0], kindLog[1]}), 64'({8'd2, 2'd1, 2'd2}));
        check(addrLog[0] == a && addrLog[1] == a && classLog[1] == eClass, "R10 same address and class",
              64'({addrLog[0], addrLog[1], classLog[1]}), 64'({a, a, eClass}));
        check(wdataLog == (wd & sizeMask(sz)), "R10 write data masked", wdataLog, wd & sizeMask(sz));
        check(rspFault == memFail && rspCause == eCause, "R10 store outcome",
              64'({rspFault, rspCause}), 64'({memFail, eCause}));
      end
      check(!rspUnsupported, "R7 accepted not unsupported", 64'(rspUnsupported), 64'd0);
    end
    @(negedge clk);
    check(!rspValid && reqReady, "R11 single response pulse", 64'({rspValid, reqReady}), 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0 && memCmd == 1'b0, "R1 reset state",
          64'({reqReady, rspValid, memCmd}), 64'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0 && memCmd == 1'b0, "R1 idle after reset",
          64'({reqReady, rspValid, memCmd}), 64'b100);
    for (int st = 0; st < 2; st++)
      for (int fe = 0; fe < (st ? 1 : 2); fe++)
        for (int sz = 0; sz < 4; sz++)
          for (int fl = 0; fl < 8; fl++)
            for (int off = 0; off < 8; off++)
              for (int bs = 0; bs < 2; bs++)
                runTxn(st[0], fe[0], sz, fl[2], fl[1], fl[0],
                       (bs ? 16'hF450 : 16'h1230) + 16'(off), (off + fl) % 3);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual hung expected response");
    finish_run();
  end

endmodule